// File: doc/BRIEF.md
# Lane-Partitioned Integer Issue Scheduler

This block is the integer scheduling stage of an out-of-order core. It holds three separate reservation stations of eight entries each, one station per ALU lane. A packing stage upstream has already chosen a lane for every macro-op. Each cycle it presents one row with at most one op per lane, and slot `l` of the row always goes to station `l`. A fused macro-op fills a single entry. The block stores no operand values. It stores only an opaque payload and two source tags.

Producers broadcast result tags on a wakeup bus. A matching tag marks a source as ready in the same cycle. Each station sends at most one ready op per cycle to its own ALU, and it picks the oldest ready entry. Ready ops in a busy station wait even when the other ALUs are idle.

A row is taken whole or not at all. A per-lane free-entry count lets the front end see back-pressure early. A flush empties every station.

Top module: `int_lane_sched`

## Requirements
- R1: Each of the three lanes holds eight entries. After reset every lane reports eight free entries. `free_cnt` carries lane `l` in bits `[4l+3:4l]`. No op issues while a station is empty.
- R2: Row slot `l` is written only into station `l`. An op from station `l` leaves only on issue port `l`, with its payload in `iss_op[16l+15:16l]`.
- R3: A station issues at most one op per cycle. A second ready op in the same station waits for a later cycle, even when the other lanes issue nothing.
- R4: When several entries of a station are ready, the one allocated earliest issues first.
- R5: `in_ready` is high only when no flush is active and every lane with `in_vld` set has at least one free entry. When `in_ready` is low, no lane takes its slot.
- R6: `free_cnt` counts a lane's unused entries. An accepted op lowers it by one from the next cycle. An issued op's entry is freed at the clock edge that ends its issue cycle.
- R7: An op is issuable only when both sources are ready. A source is ready if its `in_rdy` flag was set at entry, or if any valid wakeup tag has matched it. This includes a match in the cycle the op is accepted, and a match in the current cycle, which makes the op issuable in that same cycle.
- R8: While `flush` is high, `in_ready` and all `iss_vld` bits are low. After the flush cycle every lane reports eight free entries.
- R9: A macro-op takes one entry and issues exactly once. Its payload does not appear on the issue port again after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| in_vld | input | 3 | Row slot valid, one bit per lane |
| in_op | input | 48 | Macro-op payload per slot, 16 bits each |
| in_src0 | input | 18 | First source tag per slot, 6 bits each |
| in_src1 | input | 18 | Second source tag per slot |
| in_rdy0 | input | 3 | First source already ready per slot |
| in_rdy1 | input | 3 | Second source already ready per slot |
| wk_vld | input | 3 | Wakeup broadcast valid |
| wk_tag | input | 18 | Wakeup result tags, 6 bits each |
| in_ready | output | 1 | Row accepted this cycle |
| iss_vld | output | 3 | Issue valid per ALU lane |
| iss_op | output | 48 | Issued payload per lane |
| free_cnt | output | 12 | Free entries per lane, 4 bits each |

## Verification
A lost or stale valid bit shows up one cycle later as a `free_cnt` that disagrees with the count of accepted and issued ops. It can also show up as a payload that issues twice. A bad age ordering changes the order of payloads on a lane's issue port as soon as two entries become ready together. A missed wakeup leaves `iss_vld` low in the cycle where the tag appears. A lane leak shows up at once as the wrong `iss_vld` bit.

// File: rtl/int_lane_sched.sv
`timescale 1ns/1ps
module int_lane_sched #(
  parameter int LANES = 3,
  parameter int DEPTH = 8,
  parameter int TAGW  = 6,
  parameter int OPW   = 16,
  parameter int WAKES = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   flush,
  input  logic [LANES-1:0]                       in_vld,
  input  logic [LANES*OPW-1:0]                   in_op,
  input  logic [LANES*TAGW-1:0]                  in_src0,
  input  logic [LANES*TAGW-1:0]                  in_src1,
  input  logic [LANES-1:0]                       in_rdy0,
  input  logic [LANES-1:0]                       in_rdy1,
  input  logic [WAKES-1:0]                       wk_vld,
  input  logic [WAKES*TAGW-1:0]                  wk_tag,
  output logic                                   in_ready,
  output logic [LANES-1:0]                       iss_vld,
  output logic [LANES*OPW-1:0]                   iss_op,
  output logic [LANES*$clog2(DEPTH+1)-1:0]       free_cnt
);
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH+1);

  function automatic logic wk_hit(input logic [TAGW-1:0] t,
                                  input logic [WAKES-1:0] wv,
                                  input logic [WAKES*TAGW-1:0] wt);
    logic h;
    h = 1'b0;
    for (int w = 0; w < WAKES; w++)
      if (wv[w] && wt[w*TAGW +: TAGW] == t) h = 1'b1;
    return h;
  endfunction

  logic [LANES-1:0] lane_ok;
  logic [LANES-1:0] take;

  assign in_ready = !flush && (&lane_ok);
  assign take     = in_vld & {LANES{in_ready}};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DEPTH-1:0] v, r0, r1, m0, m1, elig;
    logic [OPW-1:0]   op  [DEPTH];
    logic [TAGW-1:0]  t0  [DEPTH];
    logic [TAGW-1:0]  t1  [DEPTH];
    logic [IDXW-1:0]  age [DEPTH];
    logic             found;
    logic [IDXW-1:0]  sel, fslot;
    logic [CNTW-1:0]  cnt;
    logic             nh0, nh1;

    always_comb begin
      found = 1'b0;
      sel   = '0;
      fslot = '0;
      for (int e = 0; e < DEPTH; e++) begin
        m0[e]   = wk_hit(t0[e], wk_vld, wk_tag);
        m1[e]   = wk_hit(t1[e], wk_vld, wk_tag);
        elig[e] = v[e] && (r0[e] || m0[e]) && (r1[e] || m1[e]);
        if (elig[e] && (!found || age[e] < age[sel])) begin
          found = 1'b1;
          sel   = IDXW'(e);
        end
      end
      for (int e = DEPTH-1; e >= 0; e--)
        if (!v[e]) fslot = IDXW'(e);
      cnt = CNTW'($countones(v));
      nh0 = wk_hit(in_src0[l*TAGW +: TAGW], wk_vld, wk_tag);
      nh1 = wk_hit(in_src1[l*TAGW +: TAGW], wk_vld, wk_tag);
    end

    assign lane_ok[l]                 = !in_vld[l] || (cnt != CNTW'(DEPTH));
    assign iss_vld[l]                 = found && !flush;
    assign iss_op[l*OPW +: OPW]       = op[sel];
    assign free_cnt[l*CNTW +: CNTW]   = CNTW'(DEPTH) - cnt;

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        v <= '0;
      end else begin
        for (int e = 0; e < DEPTH; e++) begin
          if (v[e]) begin
            if (m0[e]) r0[e] <= 1'b1;
            if (m1[e]) r1[e] <= 1'b1;
            if (found && sel == IDXW'(e))
              v[e] <= 1'b0;
            else if (found && age[e] > age[sel])
              age[e] <= age[e] - 1'b1;
          end
        end
        if (take[l]) begin
          v[fslot]   <= 1'b1;
          op[fslot]  <= in_op[l*OPW +: OPW];
          t0[fslot]  <= in_src0[l*TAGW +: TAGW];
          t1[fslot]  <= in_src1[l*TAGW +: TAGW];
          r0[fslot]  <= in_rdy0[l] || nh0;
          r1[fslot]  <= in_rdy1[l] || nh1;
          age[fslot] <= IDXW'(cnt - CNTW'(found));
        end
      end
    end
  end
endmodule

// File: rtl/int_lane_sched_chk.sv
`timescale 1ns/1ps
module int_lane_sched_chk #(
  parameter int LANES = 3,
  parameter int DEPTH = 8,
  parameter int OPW   = 16
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               flush,
  input logic [LANES-1:0]                   in_vld,
  input logic                               in_ready,
  input logic [LANES-1:0]                   iss_vld,
  input logic [LANES*OPW-1:0]               iss_op,
  input logic [LANES*$clog2(DEPTH+1)-1:0]   free_cnt
);
  localparam int CW = $clog2(DEPTH+1);

  a_r8_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (iss_vld == '0 && !in_ready));
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (free_cnt == {LANES{CW'(DEPTH)}}));

  for (genvar l = 0; l < LANES; l++) begin : g_l
    a_r6_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
      free_cnt[l*CW +: CW] <= CW'(DEPTH));
    a_r1_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (free_cnt[l*CW +: CW] == CW'(DEPTH)) |-> !iss_vld[l]);
    a_r5_take_one: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && in_vld[l] && !iss_vld[l]) |=>
        free_cnt[l*CW +: CW] == CW'($past(free_cnt[l*CW +: CW]) - 1'b1));
    a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready && !flush && !iss_vld[l]) |=>
        free_cnt[l*CW +: CW] == $past(free_cnt[l*CW +: CW]));
    a_r6_issue_returns: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_vld[l] && !(in_ready && in_vld[l])) |=>
        free_cnt[l*CW +: CW] == CW'($past(free_cnt[l*CW +: CW]) + 1'b1));
  end
endmodule

bind int_lane_sched int_lane_sched_chk #(.LANES(LANES), .DEPTH(DEPTH), .OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_vld(in_vld), .in_ready(in_ready),
  .iss_vld(iss_vld), .iss_op(iss_op), .free_cnt(free_cnt));

// File: tb/int_lane_sched_tb.sv
`timescale 1ns/1ps
module int_lane_sched_tb;
  logic        clk = 1'b0;
  logic        rst_n, flush;
  logic [2:0]  in_vld, in_rdy0, in_rdy1, wk_vld;
  logic [47:0] in_op;
  logic [17:0] in_src0, in_src1, wk_tag;
  logic        in_ready;
  logic [2:0]  iss_vld;
  logic [47:0] iss_op;
  logic [11:0] free_cnt;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  int_lane_sched u_dut (.clk(clk), .rst_n(rst_n), .flush(flush), .in_vld(in_vld),
    .in_op(in_op), .in_src0(in_src0), .in_src1(in_src1), .in_rdy0(in_rdy0),
    .in_rdy1(in_rdy1), .wk_vld(wk_vld), .wk_tag(wk_tag), .in_ready(in_ready),
    .iss_vld(iss_vld), .iss_op(iss_op), .free_cnt(free_cnt));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    in_vld = '0; in_op = '0; in_src0 = '0; in_src1 = '0;
    in_rdy0 = '0; in_rdy1 = '0; wk_vld = '0; wk_tag = '0; flush = 1'b0;
  endtask

  task automatic put(input int l, input logic [15:0] op, input logic [5:0] s0,
                     input logic r0, input logic [5:0] s1, input logic r1);
    in_vld[l] = 1'b1; in_op[l*16 +: 16] = op;
    in_src0[l*6 +: 6] = s0; in_rdy0[l] = r0;
    in_src1[l*6 +: 6] = s1; in_rdy1[l] = r1;
  endtask

  task automatic wake(input int w, input logic [5:0] t);
    wk_vld[w] = 1'b1; wk_tag[w*6 +: 6] = t;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    #1;
    check("R1 reset free", 64'(free_cnt), 64'h888);
    check("R1 reset no issue", 64'(iss_vld), 64'h0);
    check("R5 reset ready", 64'(in_ready), 64'h1);
  endtask

  task automatic t_route();
    clr(); put(1, 16'h1111, 6'd1, 1'b1, 6'd2, 1'b1);
    tick(); clr(); #1;
    check("R2 lane1 only", 64'(iss_vld), 64'h2);
    check("R2 payload lane1", 64'(iss_op[31:16]), 64'h1111);
    check("R6 free after take", 64'(free_cnt), 64'h878);
    tick(); #1;
    check("R9 no reissue", 64'(iss_vld), 64'h0);
    check("R6 freed after issue", 64'(free_cnt), 64'h888);
  endtask

  task automatic t_order();
    clr(); put(0, 16'hA0A0, 6'd5, 1'b0, 6'd3, 1'b1);
    tick(); clr(); put(0, 16'hB0B0, 6'd5, 1'b0, 6'd3, 1'b1);
    tick(); clr(); #1;
    check("R7 waits for source", 64'(iss_vld), 64'h0);
    check("R6 two held", 64'(free_cnt), 64'h886);
    wake(2, 6'd5); #1;
    check("R3 one issue, others idle", 64'(iss_vld), 64'h1);
    check("R4 oldest first", 64'(iss_op[15:0]), 64'hA0A0);
    tick(); clr(); #1;
    check("R3 second waits a cycle", 64'(iss_vld), 64'h1);
    check("R4 younger next", 64'(iss_op[15:0]), 64'hB0B0);
    tick(); #1;
    check("R9 drained", 64'(iss_vld), 64'h0);
    check("R6 lane0 empty", 64'(free_cnt), 64'h888);
  endtask

  task automatic t_capture();
    clr(); put(1, 16'h2222, 6'd4, 1'b1, 6'd12, 1'b0); wake(0, 6'd12);
    tick(); clr(); #1;
    check("R7 wakeup at entry", 64'(iss_vld), 64'h2);
    check("R7 payload", 64'(iss_op[31:16]), 64'h2222);
    tick();
  endtask

  task automatic t_stall_flush();
    for (int i = 0; i < 8; i++) begin
      clr(); put(2, 16'(16'h3000 + i), 6'd20, 1'b0, 6'd20, 1'b0);
      tick();
    end
    clr(); #1;
    check("R1 lane2 full", 64'(free_cnt), 64'h088);
    put(0, 16'h4444, 6'd1, 1'b1, 6'd1, 1'b1);
    #1; check("R5 ready with spare lane", 64'(in_ready), 64'h1);
    put(2, 16'h5555, 6'd1, 1'b1, 6'd1, 1'b1);
    #1; check("R5 stall on full lane", 64'(in_ready), 64'h0);
    tick(); clr(); #1;
    check("R5 no partial take", 64'(free_cnt), 64'h088);
    check("R5 nothing issued", 64'(iss_vld), 64'h0);
    flush = 1'b1; wake(1, 6'd20); put(0, 16'h6666, 6'd1, 1'b1, 6'd1, 1'b1); #1;
    check("R8 no issue in flush", 64'(iss_vld), 64'h0);
    check("R8 no accept in flush", 64'(in_ready), 64'h0);
    tick(); clr(); #1;
    check("R8 all empty", 64'(free_cnt), 64'h888);
    check("R8 quiet after", 64'(iss_vld), 64'h0);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clr(); rst_n = 1'b0;
    tick(); tick(); rst_n = 1'b1;
    t_reset();
    t_route();
    t_order();
    t_capture();
    t_stall_flush();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule